// File: doc/BRIEF.md
# Receive FIFO with Mode Control

This block is the receive queue of a 16550-style serial port, together with the shadow of its FIFO control register. Characters enter from one of two sources. Normally the serial-side push port feeds the queue. When loopback is active, writes to the transmit data register feed it instead, and serial-side characters are thrown away. Reads of the receive data register take the oldest character. The block reports how many characters are queued, and it pulses an overrun flag when a character arrives at a full queue.

The control register sets how deep the queue is. With the enable bit clear, the queue holds a single character, as in a 16450-style port. With the enable bit set, it uses the full depth. Changing the enable bit empties the queue. A write with the enable bit set can also empty the queue on request, through the receiver-reset bit. A write with the enable bit clear stores nothing but zero. Trigger-level interrupts, DMA signalling and the serial receiver itself belong to other blocks.

Top module: `rx_fifo_ctl`

## Requirements
- R1: After reset the queue is empty, `level` is 0, `fcr_q` is 0x00, `overrun` is 0 and the effective depth is one character.
- R2: A control write whose bit 0 differs from the stored bit 0 empties the queue. The effective depth becomes DEPTH (16 by default) when bit 0 is written as 1, and 1 when it is written as 0.
- R3: A control write with bit 0 clear stores 0x00, whatever its other bits are.
- R4: A control write with bit 0 set stores only bit 0, bit 3 (DMA mode) and bits 7..6 (trigger). The other bits of `fcr_q` read 0, so the mask is 0xC9.
- R5: A control write with bits 0 and 1 both set empties the queue, even when the port is already in full-depth mode. Bit 1 in a write with bit 0 clear has no effect on the queue when bit 0 does not change.
- R6: While `loop_en` is 1, a `tx_wr` pushes `tx_wdata`, and `line_valid` characters are discarded.
- R7: While `loop_en` is 0, `line_valid` pushes `line_data`, and `tx_wr` leaves the queue unchanged.
- R8: A push into a full queue (level equal to the effective depth) drops the character, leaves the contents unchanged, and raises `overrun` for exactly the following cycle.
- R9: `rd_data` shows the oldest character while the queue is non-empty. A `rd_pop` removes that character, so characters leave in arrival order. With the queue empty, `rd_data` is 0x00 and a pop leaves `level` at 0.
- R10: A push and a pop in the same cycle on a full queue are both accepted. No overrun is raised and `level` is unchanged.
- R11: In a cycle with a control write, pushes and pops are ignored. Only the control write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| loop_en | input | 1 | Loopback mode active |
| tx_wr | input | 1 | Transmit data register write strobe |
| tx_wdata | input | WIDTH | Transmit data register write value |
| line_valid | input | 1 | Serial-side character valid |
| line_data | input | WIDTH | Serial-side character |
| rd_pop | input | 1 | Receive data register read (pop) |
| rd_data | output | WIDTH | Oldest queued character, 0 when empty |
| level | output | $clog2(DEPTH+1) | Number of queued characters |
| overrun | output | 1 | One-cycle pulse after a dropped push |
| fcr_q | output | 8 | Stored control register fields |

## Verification
`rd_data` is combinational from the queue state. It is therefore checked in the same low clock phase in which the pop is driven, before the edge that removes the character. `level` and `fcr_q` change on the edge that takes a push, pop or control write. `overrun` is registered and is high during the cycle after the rejected push. All three are sampled shortly after that edge, against a bench model that is advanced once per driven cycle. Each stimulus is held for exactly one edge, so every expected value belongs to a single cycle.

// File: rtl/rx_fifo_ctl.sv
module rx_fifo_ctl #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctl_wr,
  input  logic [7:0]                   ctl_wdata,
  input  logic                         loop_en,
  input  logic                         tx_wr,
  input  logic [WIDTH-1:0]             tx_wdata,
  input  logic                         line_valid,
  input  logic [WIDTH-1:0]             line_data,
  input  logic                         rd_pop,
  output logic [WIDTH-1:0]             rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         overrun,
  output logic [7:0]                   fcr_q
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] KEEP_MASK = 8'hC9;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  logic             push, empty, full, do_pop, do_push, flush;
  logic [WIDTH-1:0] push_data;
  logic [CW-1:0]    cap;

  assign push      = loop_en ? tx_wr : line_valid;
  assign push_data = loop_en ? tx_wdata : line_data;
  assign cap       = fcr_q[0] ? CW'(DEPTH) : CW'(1);
  assign empty     = (level == '0);
  assign full      = (level == cap);
  assign do_pop    = !ctl_wr && rd_pop && !empty;
  assign do_push   = !ctl_wr && push && (!full || do_pop);
  assign flush     = ctl_wr && ((ctl_wdata[0] ^ fcr_q[0]) || (ctl_wdata[0] && ctl_wdata[1]));
  assign rd_data   = empty ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      overrun <= 1'b0;
      fcr_q   <= 8'h00;
    end else begin
      overrun <= !ctl_wr && push && full && !do_pop;
      if (ctl_wr) begin
        fcr_q <= ctl_wdata[0] ? (ctl_wdata & KEEP_MASK) : 8'h00;
        if (flush) begin
          wr_ptr <= '0;
          rd_ptr <= '0;
          level  <= '0;
        end
      end else begin
        if (do_push) wr_ptr <= bump(wr_ptr);
        if (do_pop)  rd_ptr <= bump(rd_ptr);
        if (do_push && !do_pop)      level <= level + CW'(1);
        else if (do_pop && !do_push) level <= level - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/rx_fifo_ctl_chk.sv
module rx_fifo_ctl_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ctl_wr,
  input logic [7:0]                 ctl_wdata,
  input logic                       tx_wr,
  input logic                       line_valid,
  input logic                       rd_pop,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       overrun,
  input logic [7:0]                 fcr_q
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] lim;
  assign lim = fcr_q[0] ? CW'(DEPTH) : CW'(1);

  assert_depth_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= lim);

  assert_mode_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && (ctl_wdata[0] != fcr_q[0]) |=> level == '0 && fcr_q[0] == $past(ctl_wdata[0]));

  assert_disable_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_wdata[0] |=> fcr_q == 8'h00);

  assert_kept_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[0] |=> (fcr_q & 8'h36) == 8'h00 && fcr_q[0] &&
      fcr_q[7:6] == $past(ctl_wdata[7:6]) && fcr_q[3] == $past(ctl_wdata[3]));

  assert_rx_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[0] && ctl_wdata[1] |=> level == '0);

  assert_overrun_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(level) == ($past(fcr_q[0]) ? CW'(DEPTH) : CW'(1)) && $stable(level));

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && level == '0 && !tx_wr && !line_valid && !ctl_wr |=> level == '0);

  assert_ctl_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && (ctl_wdata[0] == fcr_q[0]) && !(ctl_wdata[0] && ctl_wdata[1]) |=> $stable(level) && !overrun);
endmodule

bind rx_fifo_ctl rx_fifo_ctl_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .tx_wr(tx_wr), .line_valid(line_valid), .rd_pop(rd_pop),
  .level(level), .overrun(overrun), .fcr_q(fcr_q)
);

// File: tb/tb_rx_fifo_ctl.sv
`timescale 1ns/1ps
module tb_rx_fifo_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, loop_en = 1'b0, tx_wr = 1'b0, line_valid = 1'b0, rd_pop = 1'b0;
  logic [7:0] ctl_wdata = '0, tx_wdata = '0, line_data = '0;
  logic [7:0] rd_data, fcr_q;
  logic [4:0] level;
  logic overrun;

  always #2.5 clk = ~clk;

  rx_fifo_ctl dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .loop_en(loop_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .line_valid(line_valid), .line_data(line_data), .rd_pop(rd_pop),
    .rd_data(rd_data), .level(level), .overrun(overrun), .fcr_q(fcr_q)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] q[$];
  logic [7:0] fcr_m = 8'h00;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int cap_of(input logic [7:0] f);
    return f[0] ? 16 : 1;
  endfunction

  task automatic cyc(input string tag, input bit cw, input logic [7:0] cd, input bit lp,
                     input bit tw, input logic [7:0] td, input bit lv, input logic [7:0] ld,
                     input bit pop);
    bit exp_ovr, push, dpop;
    logic [7:0] pd;
    int s;
    @(negedge clk);
    ctl_wr = cw; ctl_wdata = cd; loop_en = lp; tx_wr = tw; tx_wdata = td;
    line_valid = lv; line_data = ld; rd_pop = pop;
    #1;
    if (pop) check(tag, "rd_data", int'(rd_data), (q.size() > 0) ? int'(q[0]) : 0);
    exp_ovr = 0;
    if (cw) begin
      if (cd[0] != fcr_m[0] || (cd[0] && cd[1])) q.delete();
      fcr_m = cd[0] ? (cd & 8'hC9) : 8'h00;
    end else begin
      s = q.size();
      push = lp ? tw : lv;
      pd = lp ? td : ld;
      dpop = pop && s > 0;
      if (dpop) void'(q.pop_front());
      if (push) begin
        if (s < cap_of(fcr_m) || dpop) q.push_back(pd);
        else exp_ovr = 1;
      end
    end
    @(posedge clk);
    #1;
    ctl_wr = 0; tx_wr = 0; line_valid = 0; rd_pop = 0;
    check(tag, "level", int'(level), q.size());
    check(tag, "overrun", int'(overrun), int'(exp_ovr));
    check(tag, "fcr_q", int'(fcr_q), int'(fcr_m));
  endtask

  task automatic line_in(input string tag, input logic [7:0] d);
    cyc(tag, 0, 0, 0, 0, 0, 1, d, 0);
  endtask
  task automatic pop1(input string tag);
    cyc(tag, 0, 0, loop_en, 0, 0, 0, 0, 1);
  endtask
  task automatic ctl(input string tag, input logic [7:0] d);
    cyc(tag, 1, d, loop_en, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1", "level", int'(level), 0);
    check("R1", "fcr_q", int'(fcr_q), 0);
    check("R1", "overrun", int'(overrun), 0);
    check("R1", "rd_data", int'(rd_data), 0);

    line_in("R1_depth1", 8'hA1);
    line_in("R8_depth1", 8'hA2);
    cyc("R7_tx_ignored", 0, 0, 0, 1, 8'h55, 0, 0, 0);
    pop1("R9_order");
    pop1("R9_empty");
    line_in("R2_prefill", 8'h11);
    ctl("R2_enable", 8'h01);
    for (int i = 0; i < 16; i++) line_in("R2_fill", 8'(8'h30 + i));
    line_in("R8_full", 8'hEE);
    cyc("R10_pushpop", 0, 0, 0, 0, 0, 1, 8'h77, 1);
    pop1("R9_order");
    pop1("R9_order");
    ctl("R4_noflush", 8'hCD);
    cyc("R11_ctl_blocks", 1, 8'h09, 0, 0, 0, 1, 8'h99, 1);
    ctl("R5_rxreset", 8'h03);
    line_in("R5_refill", 8'h42);
    ctl("R4_mask", 8'hFF);
    cyc("R6_loop_tx", 0, 0, 1, 1, 8'h5A, 0, 0, 0);
    cyc("R6_loop_line", 0, 0, 1, 0, 0, 1, 8'hC3, 0);
    pop1("R6_loop_read");
    ctl("R3_disable", 8'hFE);
    line_in("R5_hold", 8'h6B);
    ctl("R5_bit1_only", 8'h02);
    pop1("R5_hold_read");
    pop1("R9_empty");

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3)
        cyc("R2_R3_R4_R5_rand", 1, 8'($urandom()), loop_en, 0, 0, 0, 0, 0);
      else
        cyc("R6_R7_R8_R9_R10_rand", 0, 0, ($urandom_range(0, 9) == 0) ? ~loop_en : loop_en,
            $urandom_range(0, 1) == 1, 8'($urandom()), $urandom_range(0, 1) == 1, 8'($urandom()),
            $urandom_range(0, 2) == 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule